// File: doc/BRIEF.md
# BPSK Carrier Modulator with One-Bit Delta-Sigma Output

This block produces a sine carrier whose phase is reversed by half a cycle every time the serial data line changes level. A 32-bit phase accumulator advances by a tuning word each clock, and the upper ten bits of the phase select an entry from a table holding one full sine cycle of 16-bit signed samples. For a 1 MHz carrier from an 80 MHz system clock, the tuning word is 53687091, roughly 2^32/80.

The data line is resynchronised by two flops before its edges are detected. Each detected edge, rising or falling, toggles a half-cycle offset bit, and that bit adds half the table depth to the table address. Nothing else in the phase path changes.

The registered table sample drives two outputs. It is available in parallel for checking. It also feeds a first-order delta-sigma modulator that runs at the system clock. The modulator's single output bit needs only an external resistor and capacitor to become an analog carrier.

Top module: `bpsk_mod`

## Requirements
- R1: Each clock, the phase accumulator adds `ftw` modulo 2^32. The table address is phase bits [31:22] plus 512 when the half-cycle offset is set, taken modulo 1024. With `ftw` at zero and no offset change, the address holds still.
- R2: Table entry n holds round(32768*sin(2*pi*n/1024)), clamped to the range -32768..32767. Entry 256 is therefore 32767 and entry 768 is -32768.
- R3: Every level change on `data_in`, in either direction, toggles the half-cycle offset once. This moves the address by 512. A steady level leaves the offset unchanged.
- R4: A level change on `data_in` that is applied before clock edge k reaches the table address after edge k+2. It appears on `sample_out` after edge k+3.
- R5: `sample_out` is registered. After each edge it shows the table entry selected by the address that was current just before that edge.
- R6: `dac_out` is the carry of a 17-bit accumulator that adds (sample + 32768) each clock. Over any 65536 consecutive cycles with a constant sample s, exactly s+32768 ones appear. A sample of -32768 yields no ones. A sample of 0 gives exactly half ones over any window whose length is a multiple of 2.
- R7: A synchronous active-high `rst` clears the phase, the half-cycle offset, the modulator accumulator and the sample register. During reset `sample_out` and `dac_out` are 0, and the first address after reset is 0.
- R8: Reset clears the synchroniser flops to low. A high `data_in` present when reset releases therefore counts as one transition and sets the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | Serial data; each level change reverses the carrier phase |
| ftw | input | 32 | Frequency tuning word added to the phase every clock |
| dac_out | output | 1 | One-bit delta-sigma stream for an external RC filter |
| sample_out | output | 16 | Registered signed carrier sample |

## Verification
The flip checks assume that `data_in` settles once per clock and that it held its value through the last few cycles since reset. The bench drives the line only between edges and opens each window well after reset. The address-hold and half-step checks assume that `ftw` is deliberately parked at zero to freeze the phase. The stimulus does exactly that before every density window and before the latency probe, so a flip shows up as a clean 512-entry jump.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

    localparam int PHASE_W_DEF  = 32;
    localparam int ADDR_W_DEF   = 10;
    localparam int SAMPLE_W_DEF = 16;

    // Resynchroniser stages for the serial data line
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_pipe_t;

    // Rounded, clamped sine code for table entry idx of depth entries
    function automatic int sine_code(input int idx, input int depth, input int width);
        real full;
        real x;
        int  r;
        full = 2.0 ** (width - 1);
        x    = full * $sin(2.0 * 3.14159265358979 * real'(idx) / real'(depth));
        if (x >= 0.0) r = $rtoi(x + 0.5);
        else          r = -$rtoi(0.5 - x);
        if (r > $rtoi(full) - 1) r = $rtoi(full) - 1;
        if (r < -$rtoi(full))    r = -$rtoi(full);
        return r;
    endfunction

endpackage

// File: rtl/bpsk_data_sync.sv
module bpsk_data_sync (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    output logic flip
);
    import bpsk_pkg::*;

    sync_pipe_t pipe;
    logic       edge_seen;

    assign edge_seen = pipe.stable ^ pipe.prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            flip <= 1'b0;
        end else begin
            pipe.meta   <= data_in;
            pipe.stable <= pipe.meta;
            pipe.prev   <= pipe.stable;
            if (edge_seen) flip <= ~flip;
        end
    end
endmodule

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc #(
    parameter int PHASE_W = bpsk_pkg::PHASE_W_DEF,
    parameter int ADDR_W  = bpsk_pkg::ADDR_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] ftw,
    output logic [ADDR_W-1:0]  idx
);
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + ftw;
    end

    assign idx = phase[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/bpsk_sine_rom.sv
module bpsk_sine_rom #(
    parameter int ADDR_W   = bpsk_pkg::ADDR_W_DEF,
    parameter int SAMPLE_W = bpsk_pkg::SAMPLE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [SAMPLE_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = SAMPLE_W'(bpsk_pkg::sine_code(i, DEPTH, SAMPLE_W));
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= '0;
        else     sample <= mem[addr];
    end
endmodule

// File: rtl/bpsk_dsm.sv
module bpsk_dsm #(
    parameter int SAMPLE_W = bpsk_pkg::SAMPLE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       bit_out
);
    logic [SAMPLE_W-1:0] level;
    logic [SAMPLE_W:0]   acc;

    // Signed to offset binary: invert the sign bit
    assign level = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= {1'b0, acc[SAMPLE_W-1:0]} + {1'b0, level};
    end

    assign bit_out = acc[SAMPLE_W];
endmodule

// File: rtl/bpsk_mod.sv
module bpsk_mod #(
    parameter int PHASE_W  = bpsk_pkg::PHASE_W_DEF,
    parameter int ADDR_W   = bpsk_pkg::ADDR_W_DEF,
    parameter int SAMPLE_W = bpsk_pkg::SAMPLE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       data_in,
    input  logic [PHASE_W-1:0]         ftw,
    output logic                       dac_out,
    output logic signed [SAMPLE_W-1:0] sample_out
);
    localparam logic [ADDR_W-1:0] HALF = {1'b1, {(ADDR_W-1){1'b0}}};

    logic              flip;
    logic [ADDR_W-1:0] base_idx;
    logic [ADDR_W-1:0] rom_addr;

    bpsk_data_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .flip    (flip)
    );

    bpsk_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
        .clk (clk),
        .rst (rst),
        .ftw (ftw),
        .idx (base_idx)
    );

    assign rom_addr = flip ? base_idx + HALF : base_idx;

    bpsk_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr   (rom_addr),
        .sample (sample_out)
    );

    bpsk_dsm #(.SAMPLE_W(SAMPLE_W)) u_dsm (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample_out),
        .bit_out (dac_out)
    );
endmodule

// File: rtl/bpsk_mod_chk.sv
module bpsk_mod_chk #(
    parameter int PHASE_W  = bpsk_pkg::PHASE_W_DEF,
    parameter int ADDR_W   = bpsk_pkg::ADDR_W_DEF,
    parameter int SAMPLE_W = bpsk_pkg::SAMPLE_W_DEF
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       data_in,
    input logic [PHASE_W-1:0]         ftw,
    input logic                       flip,
    input logic [ADDR_W-1:0]          rom_addr,
    input logic signed [SAMPLE_W-1:0] sample_out,
    input logic                       dac_out
);
    localparam logic [ADDR_W-1:0]          HALF = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic signed [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign warm = (since_rst == 3'd7);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample_out == '0 && !dac_out)); // R7

    AST_FLIP_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(data_in, 3) != $past(data_in, 4)) |-> (flip != $past(flip))); // R3

    AST_FLIP_STEADY: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(data_in, 3) == $past(data_in, 4)) |-> (flip == $past(flip))); // R3

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ftw) == '0 && flip == $past(flip)) |-> (rom_addr == $past(rom_addr))); // R1

    AST_ADDR_HALF_STEP: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(ftw) == '0 && flip != $past(flip)) |-> (rom_addr == $past(rom_addr) + HALF)); // R3

    AST_NEG_FULL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(sample_out) == NEG_FULL) |-> !dac_out); // R6
endmodule

bind bpsk_mod bpsk_mod_chk #(
    .PHASE_W  (PHASE_W),
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .ftw        (ftw),
    .flip       (flip),
    .rom_addr   (rom_addr),
    .sample_out (sample_out),
    .dac_out    (dac_out)
);

// File: tb/tb_bpsk_mod.sv
module tb_bpsk_mod;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        data_in = 1'b0;
    logic [31:0] ftw = '0;
    logic        dac_out;
    logic signed [15:0] sample_out;

    bpsk_mod dut (
        .clk        (clk),
        .rst        (rst),
        .data_in    (data_in),
        .ftw        (ftw),
        .dac_out    (dac_out),
        .sample_out (sample_out)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tbl [1024];
    int exp_q [$];

    bit [31:0] acc_m;
    bit        flip_m;
    bit        h1, h2, h3;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected sample after the coming edge, then advance the model past that edge
    function automatic void model_adv(input bit [31:0] f, input bit d);
        int a;
        a = (int'(acc_m[31:22]) + (flip_m ? 512 : 0)) % 1024;
        exp_q.push_back(tbl[a]);
        if (h2 != h3) flip_m = ~flip_m;
        h3 = h2;
        h2 = h1;
        h1 = d;
        acc_m = acc_m + f;
    endfunction

    task automatic step(input bit [31:0] f, input bit d);
        @(negedge clk);
        ftw = f;
        data_in = d;
        model_adv(f, d);
    endtask

    task automatic do_reset(input bit d);
        @(negedge clk);
        rst = 1'b1;
        ftw = '0;
        data_in = d;
        exp_q.delete();
        repeat (3) @(negedge clk);
        acc_m = '0; flip_m = 1'b0; h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
        rst = 1'b0;
        model_adv(32'd0, d);
    endtask

    // Scoreboard monitor: one expected sample per edge
    always begin
        @(posedge clk);
        #2;
        if (!rst && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(int'(sample_out) == e, "R1/R2/R3/R5 scoreboard", int'(sample_out), e);
        end
    end

    task automatic count_ones(input int cycles, input bit d, input int expv, input string req);
        int ones;
        ones = 0;
        for (int i = 0; i < cycles; i++) begin
            step(32'd0, d);
            @(posedge clk);
            #2;
            ones += int'(dac_out);
        end
        chk(ones == expv, req, ones, expv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        for (int n = 0; n < 1024; n++) begin
            real x;
            int  r;
            x = 32768.0 * $sin(2.0 * 3.14159265358979 * real'(n) / 1024.0);
            r = int'(x);
            if (r > 32767)  r = 32767;
            if (r < -32768) r = -32768;
            tbl[n] = r;
        end

        // R7: outputs held at zero in reset
        repeat (3) @(negedge clk);
        chk(sample_out == 16'sd0, "R7 reset sample", int'(sample_out), 0);
        chk(dac_out == 1'b0, "R7 reset dac", int'(dac_out), 0);

        do_reset(1'b0);
        @(posedge clk); #2;
        chk(sample_out == 16'sd0, "R7 first address 0", int'(sample_out), tbl[0]);

        // R1/R2: full table sweep, one entry per cycle
        for (int i = 0; i < 1100; i++) step(32'h0040_0000, 1'b0);

        // R1: nominal 1 MHz word with data edges of various spacings (R3)
        for (int i = 0; i < 600; i++) begin
            bit d;
            d = ((i / 37) % 2 == 1) || (i % 97 == 5);
            step(32'd53687091, d);
        end

        // R2/R4: freeze at quarter phase, then probe flip latency
        do_reset(1'b0);
        step(32'h4000_0000, 1'b0);
        repeat (6) step(32'd0, 1'b0);
        @(posedge clk); #2;
        chk(sample_out == 16'sd32767, "R2 clamped peak", int'(sample_out), 32767);
        step(32'd0, 1'b1);
        @(posedge clk); #2;
        chk(sample_out == 16'sd32767, "R4 edge k", int'(sample_out), 32767);
        step(32'd0, 1'b1);
        @(posedge clk); #2;
        chk(sample_out == 16'sd32767, "R4 edge k+1", int'(sample_out), 32767);
        step(32'd0, 1'b1);
        @(posedge clk); #2;
        chk(sample_out == 16'sd32767, "R4 edge k+2", int'(sample_out), 32767);
        step(32'd0, 1'b1);
        @(posedge clk); #2;
        chk(sample_out == -16'sd32768, "R4 edge k+3", int'(sample_out), -32768);

        // R8: high data across reset release counts as a transition
        do_reset(1'b1);
        step(32'h4000_0000, 1'b1);
        repeat (6) step(32'd0, 1'b1);
        @(posedge clk); #2;
        chk(sample_out == -16'sd32768, "R8 flip from reset", int'(sample_out), -32768);

        // R6: delta-sigma densities
        do_reset(1'b0);
        step(32'h4000_0000, 1'b0);
        repeat (10) step(32'd0, 1'b0);
        count_ones(65536, 1'b0, 65535, "R6 density at +full");
        repeat (10) step(32'd0, 1'b1);
        count_ones(1024, 1'b1, 0, "R6 density at -full");
        repeat (10) step(32'd0, 1'b0);
        step(32'h4000_0000, 1'b0);
        repeat (10) step(32'd0, 1'b0);
        count_ones(2048, 1'b0, 1024, "R6 density at zero");
        step(32'h2000_0000, 1'b0);
        repeat (10) step(32'd0, 1'b0);
        count_ones(65536, 1'b0, tbl[640] + 32768, "R6 density at entry 640");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule